// File: doc/BRIEF.md
# Eight-Output Addressable Latch

This block holds a bank of single-bit outputs that are written one at a time from a serial data input. A binary address picks the target bit. Two active-low controls, a clear line and an enable line, together choose one of four behaviours:

- **Addressable latch:** write the chosen bit and leave the others alone.
- **Hold:** freeze every bit.
- **Demultiplexer:** write the chosen bit and force every other bit low.
- **Clear:** force every bit low.

The design is fully synchronous. Controls, address and data are sampled on the rising clock edge, and the outputs change only on that edge. A registered 2-bit code reports which behaviour was applied at the last edge. A separate asynchronous active-low reset clears the bank and the code at power-on, whatever the control inputs are doing.

A typical use is turning a narrow serial stream into a set of static control lines. Groups of lines are updated one bit at a time and then frozen by raising the enable.

Top module: `addr_latch_bank`

## Requirements
- R1: With clearN=1 and enableN=0 (latch behaviour), the bit chosen by the address takes dataIn at the rising edge, and every other bit keeps its stored value.
- R2: With clearN=1 and enableN=1 (hold behaviour), every output bit keeps its value at the edge, whatever the address and dataIn are.
- R3: With clearN=0 and enableN=0 (demultiplexer behaviour), the chosen bit takes dataIn at the edge and every other bit becomes 0.
- R4: With clearN=0 and enableN=1 (clear behaviour), every output bit becomes 0 at the edge, whatever the address and dataIn are.
- R5: The address is plain binary, and address value k selects outputs[k]. With the default width, 3'b000 selects bit 0 and 3'b111 selects bit 7.
- R6: All changes occur on the rising clock edge and use the inputs sampled at that edge. Input changes between edges leave the outputs unchanged until the next edge.
- R7: rstN low clears all output bits and sets modeCode to 2'b00 at once, without waiting for a clock edge.
- R8: modeCode is registered with the outputs and gives the behaviour applied at the last edge: 2'b00 clear, 2'b01 demultiplexer, 2'b10 latch, 2'b11 hold.
- R9: When enableN rises after a latch or demultiplexer write, the outputs keep exactly the pattern written at the last write edge.
- R10: When the address changes between consecutive latch-behaviour edges, only the newly addressed bit is written. Bits written earlier keep their values, with no intermediate clearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| clearN | input | 1 | Active-low clear control |
| enableN | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Binary index of the target bit |
| dataIn | input | 1 | Serial data bit |
| outBits | output | NUM_OUT | Stored output bits |
| modeCode | output | 2 | Behaviour applied at the last edge |

## Verification
The bench builds the block with its default width: a 3-bit address and eight outputs. At that width, every combination of the four behaviours, all eight addresses and both data values can be swept exhaustively against a reference model in a few dozen cycles. A fixed vector table covers the transitions that matter most: the change from demultiplexer to hold, rewriting a bit in latch behaviour, and clear with data held high. Directed steps then check that outputs stay stable between edges and that the asynchronous reset acts mid-cycle.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'b00,
    MODE_DEMUX = 2'b01,
    MODE_LATCH = 2'b10,
    MODE_HOLD  = 2'b11
  } mode_e;

  typedef struct packed {
    logic write;        // store dataIn into the addressed bit
    logic clearOthers;  // force all non-addressed bits low
    logic clearAll;     // force every bit low
  } strobe_t;

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    clearN,
  input  logic    enableN,
  output strobe_t ctl,
  output mode_e   modeQ
);

  mode_e modeNext;

  always_comb begin
    unique case ({clearN, enableN})
      2'b01:   modeNext = MODE_CLEAR;
      2'b00:   modeNext = MODE_DEMUX;
      2'b10:   modeNext = MODE_LATCH;
      default: modeNext = MODE_HOLD;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (modeNext)
      MODE_CLEAR: ctl.clearAll = 1'b1;
      MODE_DEMUX: begin
        ctl.write       = 1'b1;
        ctl.clearOthers = 1'b1;
      end
      MODE_LATCH: ctl.write = 1'b1;
      default:    ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_CLEAR;
    else       modeQ <= modeNext;
  end

  // R8: code reported after each behaviour
  p_code_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && !enableN) |=> modeQ == MODE_LATCH);
  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && enableN) |=> modeQ == MODE_HOLD);
  p_code_demux_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clearN && !enableN) |=> modeQ == MODE_DEMUX);
  p_code_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clearN && enableN) |=> modeQ == MODE_CLEAR);

endmodule

// File: rtl/addr_latch_datapath.sv
module addr_latch_datapath
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            ctl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               dataIn,
  output logic [NUM_OUT-1:0] bitsQ
);

  logic [NUM_OUT-1:0] selHot;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_cell
    assign selHot[g] = (addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          bitsQ[g] <= 1'b0;
      else if (ctl.clearAll)              bitsQ[g] <= 1'b0;
      else if (ctl.write && selHot[g])    bitsQ[g] <= dataIn;
      else if (ctl.clearOthers)           bitsQ[g] <= 1'b0;
    end
  end

  // R1 / R10: latch write leaves non-addressed bits untouched
  p_latch_keep_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.write && !ctl.clearOthers) |=>
      (((bitsQ ^ $past(bitsQ)) & ~$past(selHot)) == '0));
  // R5: addressed bit carries the sampled data
  p_addr_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.write |=> bitsQ[$past(addr)] == $past(dataIn));
  // R2: no strobe means no change
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.write && !ctl.clearAll) |=> $stable(bitsQ));
  // R3: demultiplexer leaves at most one bit set
  p_demux_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearOthers |=> $onehot0(bitsQ));
  // R4: clear empties the bank
  p_clear_all_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |=> bitsQ == '0);

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int NUM_OUT = 1 << ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearN,
  input  logic               enableN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               dataIn,
  output logic [NUM_OUT-1:0] outBits,
  output logic [1:0]         modeCode
);

  strobe_t ctl;
  mode_e   modeQ;

  addr_latch_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clearN  (clearN),
    .enableN (enableN),
    .ctl     (ctl),
    .modeQ   (modeQ)
  );

  addr_latch_datapath #(
    .ADDR_W  (ADDR_W),
    .NUM_OUT (NUM_OUT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .addr   (addr),
    .dataIn (dataIn),
    .bitsQ  (outBits)
  );

  assign modeCode = modeQ;

endmodule

// File: tb/addr_latch_bank_test.sv
`timescale 1ns/100ps
module addr_latch_bank_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clearN = 1'b1;
  logic       enableN = 1'b1;
  logic [2:0] addr = '0;
  logic       dataIn = 1'b0;
  logic [7:0] outBits;
  logic [1:0] modeCode;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_latch_bank uut (
    .clk(clk), .rstN(rstN), .clearN(clearN), .enableN(enableN),
    .addr(addr), .dataIn(dataIn), .outBits(outBits), .modeCode(modeCode)
  );

  // vector: clearN, enableN, addr, data, expected bits, expected code
  localparam logic [15:0] VEC [12] = '{
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h08, 2'b10},  // R1 latch
    {1'b1, 1'b0, 3'd6, 1'b1, 8'h48, 2'b10},  // R10 new address
    {1'b1, 1'b0, 3'd3, 1'b0, 8'h40, 2'b10},  // R1 rewrite 0
    {1'b1, 1'b1, 3'd0, 1'b1, 8'h40, 2'b11},  // R2 hold ignores data
    {1'b1, 1'b0, 3'd0, 1'b1, 8'h41, 2'b10},  // R5 address 0
    {1'b0, 1'b0, 3'd5, 1'b1, 8'h20, 2'b01},  // R3 demux
    {1'b0, 1'b0, 3'd2, 1'b0, 8'h00, 2'b01},  // R3 demux zero
    {1'b1, 1'b0, 3'd7, 1'b1, 8'h80, 2'b10},  // R5 address 7
    {1'b0, 1'b1, 3'd7, 1'b1, 8'h00, 2'b00},  // R4 clear
    {1'b1, 1'b0, 3'd1, 1'b1, 8'h02, 2'b10},  // R1
    {1'b0, 1'b0, 3'd4, 1'b1, 8'h10, 2'b01},  // R3
    {1'b1, 1'b1, 3'd4, 1'b0, 8'h10, 2'b11}   // R9 demux then hold
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cn, input logic en, input logic [2:0] a, input logic d);
    @(negedge clk);
    clearN = cn; enableN = en; addr = a; dataIn = d;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] model(input logic [7:0] cur, input logic cn,
                                       input logic en, input logic [2:0] a, input logic d);
    logic [7:0] nxt = cur;
    if (!cn && en)       nxt = '0;
    else if (!cn && !en) begin nxt = '0; nxt[a] = d; end
    else if (cn && !en)  nxt[a] = d;
    return nxt;
  endfunction

  function automatic logic [1:0] codeOf(input logic cn, input logic en);
    if (!cn) return en ? 2'b00 : 2'b01;
    return en ? 2'b11 : 2'b10;
  endfunction

  initial begin
    logic [7:0] expBits;
    repeat (2) @(posedge clk);
    #1;
    check("R7 reset bits", outBits, 8'h00);
    check("R7 reset code", {6'b0, modeCode}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // table walk
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][15], VEC[i][14], VEC[i][13:11], VEC[i][10]);
      check($sformatf("table %0d bits R1-group", i), outBits, VEC[i][9:2]);
      check($sformatf("table %0d code R8", i), {6'b0, modeCode}, {6'b0, VEC[i][1:0]});
    end

    // exhaustive sweep with reference model
    expBits = outBits;
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 8; a++) begin
        for (int d = 0; d < 2; d++) begin
          logic cn = m[1];
          logic en = m[0];
          expBits = model(expBits, cn, en, 3'(a), d[0]);
          step(cn, en, 3'(a), d[0]);
          check($sformatf("sweep m%0d a%0d d%0d R5", m, a, d), outBits, expBits);
          check("sweep code R8", {6'b0, modeCode}, {6'b0, codeOf(cn, en)});
        end
      end
    end

    // R6: mid-cycle input change has no effect before the edge
    step(1'b0, 1'b1, 3'd0, 1'b0);
    step(1'b1, 1'b0, 3'd2, 1'b1);
    check("R6 setup write", outBits, 8'h04);
    @(negedge clk);
    addr = 3'd5; dataIn = 1'b1;
    #1;
    check("R6 between edges", outBits, 8'h04);
    @(posedge clk);
    #1;
    check("R6 after edge", outBits, 8'h24);

    // R9: enable rises right after a latch write
    step(1'b1, 1'b1, 3'd1, 1'b1);
    check("R9 latch then hold", outBits, 8'h24);
    step(1'b1, 1'b1, 3'd6, 1'b1);
    check("R2 hold second edge", outBits, 8'h24);

    // R7: asynchronous reset mid-cycle
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    check("R7 async bits", outBits, 8'h00);
    check("R7 async code", {6'b0, modeCode}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, 1'b0, 3'd7, 1'b1);
    check("R1 after reset", outBits, 8'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule